// File: doc/BRIEF.md
# Register-Programmed Display Timing Generator

This block produces the sync, data-enable and pixel outputs for a display link from geometry that software loads through a simple register write port. A line counter runs across each line of pixels. A frame counter runs across the whole frame, and it counts pixel clocks rather than lines. Both sync pulses and the active window are found by comparing these counters with the programmed bounds. The active window bounds are absolute positions measured from the start of the sync pulse.

Inside the active window the block takes pixels from an upstream source over a ready/valid handshake. If the source has no pixel ready, the block can drive a substitute underflow colour, and a sticky flag records the event. Outside the window it drives a border colour.

Register writes land in a shadow copy. The shadow copy moves into the working copy only at a frame boundary, so no frame ever mixes old and new settings. While the block is disabled, the working copy follows the shadow copy on every clock, so a new enable starts a frame at the next clock edge.

Top module: `disp_timing_gen`

## Requirements
- R1: After a synchronous active-low reset the block is disabled. Every register reads as zero, hsync_o and vsync_o are low, de_o is low, pix_o is zero and underflow_o is low.
- R2: The line counter runs from 0 to line_total-1 (register address 1), then wraps to 0. hsync is active while the line counter is below the pulse width (address 2).
- R3: The frame counter counts pixel clocks from 0 to frame_total-1 (address 3). vsync is active while the frame counter is below the sync length in pixel clocks (address 4).
- R4: de_o is high only when both conditions hold: the line counter lies within [h_start, h_end] (addresses 5 and 6, inclusive), and the frame counter lies within [v_start+skew, v_end+skew] (addresses 7 and 8, skew at address 12, inclusive).
- R5: In the polarity register (address 9), bit 0 makes hsync_o active-low and bit 1 makes vsync_o active-low. With a bit clear, that sync is active-high.
- R6: px_in_ready equals de_o. In a cycle where de_o and px_in_valid are both high, pix_o carries px_in_data.
- R7: The underflow register (address 11) holds a colour in bits 23:0 and a recovery enable in bit 24. When de_o is high, px_in_valid is low and recovery is enabled, pix_o shows that colour. With recovery disabled, pix_o shows px_in_data unchanged.
- R8: When de_o is low, pix_o shows the border colour (address 10, bits 23:0).
- R9: underflow_o goes high one clock after any cycle in which de_o is high and px_in_valid is low, and it then stays high. A write of 1 to bit 0 of address 13 clears it. A new underflow in the same cycle as the clear takes priority over the clear.
- R10: Writes to any register, including a write of 0 to the enable register (address 0, bit 0), reach the outputs only after the clock edge that ends the last pixel clock of the running frame (frame counter = frame_total-1). At that edge both counters restart at 0.
- R11: While disabled, both counters stay at zero, each sync sits at its inactive level, and de_o is low. A write of 1 to the enable bit starts the counters from 0 one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| px_in_data | input | 24 | Upstream pixel data |
| px_in_valid | input | 1 | Upstream pixel valid |
| px_in_ready | output | 1 | Pixel accepted this cycle when valid is also high |
| hsync_o | output | 1 | Horizontal sync, polarity programmable |
| vsync_o | output | 1 | Vertical sync, polarity programmable |
| de_o | output | 1 | Data enable |
| pix_o | output | 24 | Output pixel |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
hsync, vsync, data-enable, ready and the pixel bus are combinational from the counters, the working registers and the upstream inputs. They are therefore valid in the same cycle. The underflow flag shows an event one clock later. A register write takes hold in the shadow copy at its write edge. The write reaches the outputs one edge later if the block is disabled, or at the frame-ending edge if it is running. The bench keeps its own model of these registers and updates it on the same rising edges, with inputs driven 2 ns after each edge. At every falling edge it queues the expected outputs for that cycle and compares them with the design, so every result is checked in exactly the cycle it is due.

// File: rtl/dtg_pkg.sv
// Shared widths, register addresses and the configuration record of the
// display timing generator. Assumes one clock domain.
package dtg_pkg;
    parameter int H_W    = 12;   // line counter / horizontal field width
    parameter int F_W    = 24;   // frame counter / vertical field width
    parameter int PIX_W  = 24;   // pixel bus width
    parameter int ADDR_W = 4;
    parameter int DATA_W = 32;
    localparam int UF_REC_BIT = PIX_W;  // recovery enable sits above the colour

    typedef enum logic [ADDR_W-1:0] {
        ADR_ENABLE  = 4'd0,
        ADR_LTOT    = 4'd1,
        ADR_HSW     = 4'd2,
        ADR_FTOT    = 4'd3,
        ADR_VLEN    = 4'd4,
        ADR_HSTART  = 4'd5,
        ADR_HEND    = 4'd6,
        ADR_VSTART  = 4'd7,
        ADR_VEND    = 4'd8,
        ADR_POL     = 4'd9,
        ADR_BORDER  = 4'd10,
        ADR_UFCOL   = 4'd11,
        ADR_SKEW    = 4'd12,
        ADR_STATUS  = 4'd13
    } reg_adr_e;

    typedef struct packed {
        logic             en;
        logic [H_W-1:0]   ltot;
        logic [H_W-1:0]   hsw;
        logic [F_W-1:0]   ftot;
        logic [F_W-1:0]   vlen;
        logic [H_W-1:0]   hst;
        logic [H_W-1:0]   hend;
        logic [F_W-1:0]   vst;
        logic [F_W-1:0]   vend;
        logic [F_W-1:0]   skew;
        logic             pol_h;
        logic             pol_v;
        logic [PIX_W-1:0] border;
        logic             uf_rec;
        logic [PIX_W-1:0] uf_col;
    } cfg_t;
endpackage

// File: rtl/dtg_regs.sv
// Shadow register file and sticky underflow flag. Writes land here at once;
// the timing core decides when the shadow copy becomes active.
// Assumes single-cycle write strobes and synchronous active-low reset.
module dtg_regs
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uf_hit,
    output cfg_t              shadow,
    output logic              uf_flag
);
    logic clr_hit;
    assign clr_hit = wr_en && (addr == ADR_STATUS) && wdata[0];

    // Capture register writes into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_ENABLE: shadow.en     <= wdata[0];
                ADR_LTOT:   shadow.ltot   <= wdata[H_W-1:0];
                ADR_HSW:    shadow.hsw    <= wdata[H_W-1:0];
                ADR_FTOT:   shadow.ftot   <= wdata[F_W-1:0];
                ADR_VLEN:   shadow.vlen   <= wdata[F_W-1:0];
                ADR_HSTART: shadow.hst    <= wdata[H_W-1:0];
                ADR_HEND:   shadow.hend   <= wdata[H_W-1:0];
                ADR_VSTART: shadow.vst    <= wdata[F_W-1:0];
                ADR_VEND:   shadow.vend   <= wdata[F_W-1:0];
                ADR_POL: begin
                    shadow.pol_h <= wdata[0];
                    shadow.pol_v <= wdata[1];
                end
                ADR_BORDER: shadow.border <= wdata[PIX_W-1:0];
                ADR_UFCOL: begin
                    shadow.uf_col <= wdata[PIX_W-1:0];
                    shadow.uf_rec <= wdata[UF_REC_BIT];
                end
                ADR_SKEW:   shadow.skew   <= wdata[F_W-1:0];
                default: ;
            endcase
        end
    end

    // Sticky underflow flag: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       uf_flag <= 1'b0;
        else if (uf_hit)  uf_flag <= 1'b1;
        else if (clr_hit) uf_flag <= 1'b0;
    end
endmodule

// File: rtl/dtg_timing.sv
// Working configuration and line/frame counters. The working copy reloads
// from the shadow copy on every clock while disabled, and only on the last
// pixel clock of a frame while running. Both counters restart on a reload.
// Assumes frame_total is a non-zero multiple of line_total when enabled.
module dtg_timing
    import dtg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  cfg_t           shadow,
    output cfg_t           act,
    output logic [H_W-1:0] hcnt,
    output logic [F_W-1:0] fcnt
);
    logic frame_last;
    logic reload;

    assign frame_last = act.en && (fcnt == act.ftot - F_W'(1));
    assign reload     = !act.en || frame_last;

    // Move the shadow copy into the working copy at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)      act <= '0;
        else if (reload) act <= shadow;
    end

    // Advance the line and frame counters, restarting on reload.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            hcnt <= '0;
            fcnt <= '0;
        end else begin
            hcnt <= (hcnt == act.ltot - H_W'(1)) ? '0 : hcnt + H_W'(1);
            fcnt <= fcnt + F_W'(1);
        end
    end
endmodule

// File: rtl/dtg_outmux.sv
// Sync decode, active-window decode and pixel source selection. Purely
// combinational; assumes the working configuration is stable within a frame.
module dtg_outmux
    import dtg_pkg::*;
(
    input  cfg_t             act,
    input  logic [H_W-1:0]   hcnt,
    input  logic [F_W-1:0]   fcnt,
    input  logic [PIX_W-1:0] px_data,
    input  logic             px_valid,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             ready,
    output logic [PIX_W-1:0] pix,
    output logic             uf_hit
);
    logic           h_in;
    logic           v_in;
    logic [F_W:0]   v_lo;
    logic [F_W:0]   v_hi;

    assign v_lo = {1'b0, act.vst}  + {1'b0, act.skew};
    assign v_hi = {1'b0, act.vend} + {1'b0, act.skew};

    // Window and sync decode from the counters.
    always_comb begin
        h_in  = (hcnt >= act.hst) && (hcnt <= act.hend);
        v_in  = ({1'b0, fcnt} >= v_lo) && ({1'b0, fcnt} <= v_hi);
        de    = act.en && h_in && v_in;
        hsync = (act.en && (hcnt < act.hsw))  ^ act.pol_h;
        vsync = (act.en && (fcnt < act.vlen)) ^ act.pol_v;
    end

    // Pick the pixel source and flag a starved active cycle.
    always_comb begin
        ready  = de;
        uf_hit = de && !px_valid;
        if (!de)                        pix = act.border;
        else if (!px_valid && act.uf_rec) pix = act.uf_col;
        else                            pix = px_data;
    end
endmodule

// File: rtl/disp_timing_gen.sv
// Top of the register-programmed display timing generator: shadow
// registers, frame-synchronous working copy with counters, output decode.
module disp_timing_gen
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [PIX_W-1:0]  px_in_data,
    input  logic              px_in_valid,
    output logic              px_in_ready,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [PIX_W-1:0]  pix_o,
    output logic              underflow_o
);
    cfg_t           shadow;
    cfg_t           act_q;
    logic [H_W-1:0] hcnt;
    logic [F_W-1:0] fcnt;
    logic           uf_hit;

    dtg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .uf_hit(uf_hit), .shadow(shadow), .uf_flag(underflow_o)
    );

    dtg_timing u_timing (
        .clk(clk), .rst_n(rst_n), .shadow(shadow), .act(act_q),
        .hcnt(hcnt), .fcnt(fcnt)
    );

    dtg_outmux u_outmux (
        .act(act_q), .hcnt(hcnt), .fcnt(fcnt), .px_data(px_in_data),
        .px_valid(px_in_valid), .hsync(hsync_o), .vsync(vsync_o), .de(de_o),
        .ready(px_in_ready), .pix(pix_o), .uf_hit(uf_hit)
    );
endmodule

// File: rtl/dtg_checker.sv
// Temporal checks on the timing generator, bound to the top module.
module dtg_checker
    import dtg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input cfg_t              act_q,
    input logic [H_W-1:0]    hcnt,
    input logic [F_W-1:0]    fcnt,
    input logic              de_o,
    input logic              px_in_valid,
    input logic              underflow_o,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata
);
    logic clr_req;
    assign clr_req = reg_wr_en && (reg_addr == ADR_STATUS) && reg_wdata[0];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q.en |-> (hcnt == '0 && fcnt == '0 && !de_o)); // R11

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.en && fcnt != act_q.ftot - F_W'(1) && hcnt != act_q.ltot - H_W'(1))
        |=> hcnt == $past(hcnt) + H_W'(1)); // R2

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.en && fcnt != act_q.ftot - F_W'(1)) |=> fcnt == $past(fcnt) + F_W'(1)); // R3

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.en && fcnt != act_q.ftot - F_W'(1)) |=> $stable(act_q)); // R10

    AST_UF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o && !px_in_valid) |=> underflow_o); // R9

    AST_UF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && !clr_req) |=> underflow_o); // R9
endmodule

bind disp_timing_gen dtg_checker chk_i (
    .clk(clk), .rst_n(rst_n), .act_q(act_q), .hcnt(hcnt), .fcnt(fcnt),
    .de_o(de_o), .px_in_valid(px_in_valid), .underflow_o(underflow_o),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/disp_timing_gen_tb_top.sv
// Scoreboard bench: a requirement-level model queues the expected outputs
// for each cycle, and the monitor pops them and compares them with the design.
module disp_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [23:0] px_in_data = '0;
    logic        px_in_valid = 1'b0;
    logic        px_in_ready, hsync_o, vsync_o, de_o, underflow_o;
    logic [23:0] pix_o;

    int n_chk = 0;
    int n_bad = 0;
    string phase = "R1 reset";
    int vmode = 0;
    int unsigned cyc = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    disp_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .px_in_data(px_in_data), .px_in_valid(px_in_valid),
        .px_in_ready(px_in_ready), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .pix_o(pix_o), .underflow_o(underflow_o)
    );

    // model registers: s_* written by the port, a_* the working copy
    logic [31:0] s_r [0:12];
    logic [31:0] a_r [0:12];
    int unsigned mh, mf;
    logic        muf;

    typedef struct packed {
        logic hs, vs, de, rdy, uf;
        logic [23:0] pix;
    } exp_t;
    exp_t q[$];

    function automatic logic m_de();
        int unsigned vlo, vhi;
        vlo = a_r[7] + a_r[12];
        vhi = a_r[8] + a_r[12];
        return a_r[0][0] && mh >= a_r[5] && mh <= a_r[6] && mf >= vlo && mf <= vhi;
    endfunction

    // Upstream source: new data every cycle, valid chosen by pattern.
    always @(posedge clk) begin
        #2;
        cyc++;
        px_in_data = {8'h5A, cyc[15:0]};
        case (vmode)
            0: px_in_valid = 1'b1;
            1: px_in_valid = cyc[0] ^ cyc[2];
            default: px_in_valid = 1'b0;
        endcase
    end

    // Reference state update on each rising edge, following R2 R3 R9 R10 R11.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 13; i++) begin s_r[i] = '0; a_r[i] = '0; end
            mh = 0; mf = 0; muf = 1'b0;
        end else begin
            logic dn, ld;
            dn = m_de();
            if (dn && !px_in_valid) muf = 1'b1;
            else if (reg_wr_en && reg_addr == 4'd13 && reg_wdata[0]) muf = 1'b0;
            ld = !a_r[0][0] || (mf == a_r[3] - 1);
            if (ld) begin
                for (int i = 0; i < 13; i++) a_r[i] = s_r[i];
                mh = 0; mf = 0;
            end else begin
                mh = (mh == a_r[1] - 1) ? 0 : mh + 1;
                mf = mf + 1;
            end
            if (reg_wr_en && reg_addr <= 4'd12) begin
                case (reg_addr)
                    4'd0:  s_r[0]  = {31'd0, reg_wdata[0]};
                    4'd1, 4'd2, 4'd5, 4'd6: s_r[reg_addr] = {20'd0, reg_wdata[11:0]};
                    4'd9:  s_r[9]  = {30'd0, reg_wdata[1:0]};
                    4'd10: s_r[10] = {8'd0, reg_wdata[23:0]};
                    4'd11: s_r[11] = {7'd0, reg_wdata[24:0]};
                    default: s_r[reg_addr] = {8'd0, reg_wdata[23:0]};
                endcase
            end
        end
    end

    task automatic cmp1(string tag, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
        end
    endtask

    // Driver side queues the expected item; monitor pops and compares.
    always @(negedge clk) begin
        if (cmp_on) begin
            exp_t e, g;
            logic d;
            d = m_de();
            e.de  = d;
            e.rdy = d;
            e.hs  = (a_r[0][0] && mh < a_r[2]) ^ a_r[9][0];
            e.vs  = (a_r[0][0] && mf < a_r[4]) ^ a_r[9][1];
            e.uf  = muf;
            if (!d) e.pix = a_r[10][23:0];
            else if (!px_in_valid && a_r[11][24]) e.pix = a_r[11][23:0];
            else e.pix = px_in_data;
            q.push_back(e);
            g = q.pop_front();
            n_chk++;
            cmp1("R2 hsync", {31'd0, hsync_o}, {31'd0, g.hs});
            cmp1("R3 vsync", {31'd0, vsync_o}, {31'd0, g.vs});
            cmp1("R4 de", {31'd0, de_o}, {31'd0, g.de});
            cmp1("R6 ready", {31'd0, px_in_ready}, {31'd0, g.rdy});
            cmp1("R7 pix", {8'd0, pix_o}, {8'd0, g.pix});
            cmp1("R9 underflow", {31'd0, underflow_o}, {31'd0, g.uf});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired [%s]", phase);
        finish_up();
    end

    initial begin
        run(3); #2;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: everything idle and zero straight after reset
        n_chk++;
        cmp1("R1 reset outputs", {5'd0, hsync_o, vsync_o, de_o, underflow_o, pix_o}, 32'd0);
        cmp_on = 1;
        // geometry: 8 px/line, 6 lines, 2 sync lines, active lines 3..4, px 3..6
        wr(4'd1, 8); wr(4'd2, 2); wr(4'd3, 48); wr(4'd4, 16);
        wr(4'd5, 3); wr(4'd6, 6); wr(4'd7, 24); wr(4'd8, 39);
        wr(4'd10, 32'h102030);
        phase = "R2 R3 R4 R6 R11 start";
        wr(4'd0, 1);
        run(110);
        phase = "R10 width change mid-frame";
        wr(4'd2, 3);
        run(50);
        phase = "R10 disable mid-frame";
        wr(4'd0, 0);
        run(60);
        phase = "R11 idle";
        vmode = 2;
        run(20);
        vmode = 0;
        phase = "R5 polarity";
        wr(4'd9, 3); wr(4'd0, 1);
        run(100);
        phase = "R7 recovery colour";
        vmode = 1;
        wr(4'd11, 32'h01FF00FF);
        run(100);
        phase = "R7 recovery off";
        wr(4'd11, 32'h00FF00FF);
        run(60);
        phase = "R9 clear";
        vmode = 0;
        wr(4'd13, 1);
        run(60);
        phase = "R9 set beats clear";
        vmode = 2;
        wr(4'd13, 1);
        run(60);
        vmode = 0;
        phase = "R4 skew";
        wr(4'd12, 8);
        run(100);
        phase = "R8 border";
        wr(4'd10, 32'hABCDEF);
        run(60);
        @(negedge clk); #1;
        finish_up();
    end
endmodule